// File: doc/BRIEF.md
# Target Access Security Firewall

This block stands between bus initiators and a small set of targets and decides, one transaction at a time, whether a request may reach its target. Each target sits in either the secure or the non-secure zone, chosen by one bit per target in a bank of security control registers. Each transaction is either secure or non-secure. That state comes from a flag on the request, unless a per-initiator override forces it to a programmed value. A request that fails the check never reaches the target. Instead, the requester receives an error response with zero data. A request that passes is forwarded one cycle later, and the target's response is relayed back to the requester one cycle after it arrives.

A separate register port programs the zone bits and the override registers. Only secure accesses may use it. A non-secure access, whether a read or a write, receives an error response and changes nothing. The override registers reset to the parameter `INIT_SEC_RST`, so a chosen set of initiators is treated as secure from reset onward. All targets start in the secure zone. Requests are handled one at a time: the requester waits for a response before it issues the next request.

Top module: `fw_target_gate`

## Requirements
- R1: Register select 0 holds one bit per target, where bit t = 1 places target t in the non-secure zone. Every bit is 0 (secure) after reset.
- R2: A non-secure request to a secure target produces, on the next cycle, `up_rsp_valid`=1 with `up_rsp_err`=1 and zero data. No target request is issued.
- R3: A request to a non-secure target, or a secure request to any existing target, raises `tgt_req_valid` for one cycle on the next cycle. The forwarded index, address, write flag and write data match the request.
- R4: The effective security of a request is bit i of the override value register (select 2) when bit i of the override enable register (select 1) is set, where i is the initiator number. Otherwise it is `up_req_sec`.
- R5: After reset, both override registers read back as `INIT_SEC_RST`.
- R6: The target index is taken from the top `IDXW` address bits. An index of `NUM_TGT` or higher produces an error response on the next cycle, and no target request is issued.
- R7: A target response (`tgt_rsp_valid`) is returned on the next cycle as `up_rsp_valid`, carrying the target's data and error flag unchanged.
- R8: A non-secure access on the register port is answered on the next cycle with `cfg_rsp_err`=1 and zero data. No register changes.
- R9: A secure register read returns the selected register, zero-extended. A secure write updates it. Select 3 is unused and gives an error for any access.
- R10: A request presented in the same cycle as a zone write is checked against the old zone bits. The new value applies from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req_valid | input | 1 | Request strobe from the initiator |
| up_req_write | input | 1 | Request is a write |
| up_req_addr | input | AW | Request address; the top IDXW bits select the target |
| up_req_wdata | input | DW | Write data |
| up_req_init | input | IW | Initiator number |
| up_req_sec | input | 1 | Per-request secure flag |
| up_rsp_valid | output | 1 | Response strobe to the initiator |
| up_rsp_err | output | 1 | Response error |
| up_rsp_rdata | output | DW | Response data |
| tgt_req_valid | output | 1 | Forwarded request strobe |
| tgt_req_idx | output | IDXW | Selected target |
| tgt_req_write | output | 1 | Forwarded write flag |
| tgt_req_addr | output | AW | Forwarded address |
| tgt_req_wdata | output | DW | Forwarded write data |
| tgt_rsp_valid | input | 1 | Target response strobe |
| tgt_rsp_err | input | 1 | Target response error |
| tgt_rsp_rdata | input | DW | Target response data |
| cfg_valid | input | 1 | Register port access strobe |
| cfg_write | input | 1 | Register access is a write |
| cfg_sel | input | 2 | Register select: 0 zone, 1 override enable, 2 override value |
| cfg_wdata | input | DW | Register write data |
| cfg_sec | input | 1 | Register access is secure |
| cfg_rsp_valid | output | 1 | Register response strobe |
| cfg_rsp_err | output | 1 | Register response error |
| cfg_rsp_rdata | output | DW | Register read data |

## Verification
Corrupt state in the firewall would show at the ports within one cycle. A wrong zone bit or a wrong override bit flips the next request between forwarded and rejected. A protection slip in the register bank would appear as a changed read-back value after a rejected non-secure write. The bench therefore pairs every register change with the very next request and a read-back of the affected register. It also presents a request in the same cycle as a zone write, to pin down which value of the zone bits the check uses.

// File: rtl/fw_pkg.sv
package fw_pkg;
  typedef enum logic [1:0] {
    SEL_ZONE    = 2'd0,
    SEL_OVR_EN  = 2'd1,
    SEL_OVR_VAL = 2'd2,
    SEL_RSVD    = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/fw_cfg_regs.sv
module fw_cfg_regs
  import fw_pkg::*;
#(
  parameter int                NUM_TGT      = 6,
  parameter int                NUM_INIT     = 4,
  parameter int                DW           = 32,
  parameter logic [NUM_INIT-1:0] INIT_SEC_RST = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_valid,
  input  logic                cfg_write,
  input  logic [1:0]          cfg_sel,
  input  logic [DW-1:0]       cfg_wdata,
  input  logic                cfg_sec,
  output logic                cfg_rsp_valid,
  output logic                cfg_rsp_err,
  output logic [DW-1:0]       cfg_rsp_rdata,
  output logic [NUM_TGT-1:0]  zone_ns,
  output logic [NUM_INIT-1:0] ovr_en,
  output logic [NUM_INIT-1:0] ovr_val
);
  cfg_sel_e sel;
  logic     unused_wdata;

  assign sel          = cfg_sel_e'(cfg_sel);
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      zone_ns       <= '0;
      ovr_en        <= INIT_SEC_RST;
      ovr_val       <= INIT_SEC_RST;
      cfg_rsp_valid <= 1'b0;
      cfg_rsp_err   <= 1'b0;
      cfg_rsp_rdata <= '0;
    end else begin
      cfg_rsp_valid <= cfg_valid;
      cfg_rsp_err   <= 1'b0;
      cfg_rsp_rdata <= '0;
      if (cfg_valid) begin
        if (!cfg_sec || sel == SEL_RSVD) begin
          cfg_rsp_err <= 1'b1;
        end else if (cfg_write) begin
          case (sel)
            SEL_ZONE:    zone_ns <= cfg_wdata[NUM_TGT-1:0];
            SEL_OVR_EN:  ovr_en  <= cfg_wdata[NUM_INIT-1:0];
            SEL_OVR_VAL: ovr_val <= cfg_wdata[NUM_INIT-1:0];
            default:     ;
          endcase
        end else begin
          case (sel)
            SEL_ZONE:    cfg_rsp_rdata <= DW'(zone_ns);
            SEL_OVR_EN:  cfg_rsp_rdata <= DW'(ovr_en);
            SEL_OVR_VAL: cfg_rsp_rdata <= DW'(ovr_val);
            default:     cfg_rsp_rdata <= '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fw_decide.sv
module fw_decide #(
  parameter int NUM_TGT  = 6,
  parameter int NUM_INIT = 4,
  parameter int IDXW     = 3,
  parameter int IW       = 2
) (
  input  logic [IDXW-1:0]     idx,
  input  logic [IW-1:0]       init,
  input  logic                req_sec,
  input  logic [NUM_TGT-1:0]  zone_ns,
  input  logic [NUM_INIT-1:0] ovr_en,
  input  logic [NUM_INIT-1:0] ovr_val,
  output logic                allow
);
  logic               eff_sec;
  logic [NUM_TGT-1:0] hit;

  assign eff_sec = ovr_en[init] ? ovr_val[init] : req_sec;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_hit
    assign hit[g] = (idx == IDXW'(g)) && (zone_ns[g] || eff_sec);
  end

  assign allow = |hit;
endmodule

// File: rtl/fw_target_gate.sv
module fw_target_gate #(
  parameter int                  AW           = 16,
  parameter int                  DW           = 32,
  parameter int                  NUM_TGT      = 6,
  parameter int                  NUM_INIT     = 4,
  parameter logic [NUM_INIT-1:0] INIT_SEC_RST = 4'b0011,
  localparam int                 IDXW         = $clog2(NUM_TGT),
  localparam int                 IW           = $clog2(NUM_INIT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            up_req_valid,
  input  logic            up_req_write,
  input  logic [AW-1:0]   up_req_addr,
  input  logic [DW-1:0]   up_req_wdata,
  input  logic [IW-1:0]   up_req_init,
  input  logic            up_req_sec,
  output logic            up_rsp_valid,
  output logic            up_rsp_err,
  output logic [DW-1:0]   up_rsp_rdata,
  output logic            tgt_req_valid,
  output logic [IDXW-1:0] tgt_req_idx,
  output logic            tgt_req_write,
  output logic [AW-1:0]   tgt_req_addr,
  output logic [DW-1:0]   tgt_req_wdata,
  input  logic            tgt_rsp_valid,
  input  logic            tgt_rsp_err,
  input  logic [DW-1:0]   tgt_rsp_rdata,
  input  logic            cfg_valid,
  input  logic            cfg_write,
  input  logic [1:0]      cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            cfg_sec,
  output logic            cfg_rsp_valid,
  output logic            cfg_rsp_err,
  output logic [DW-1:0]   cfg_rsp_rdata
);
  logic [NUM_TGT-1:0]  zone_ns_q;
  logic [NUM_INIT-1:0] ovr_en_q;
  logic [NUM_INIT-1:0] ovr_val_q;
  logic [IDXW-1:0]     req_idx;
  logic                allow;

  assign req_idx = up_req_addr[AW-1 -: IDXW];

  fw_cfg_regs #(
    .NUM_TGT(NUM_TGT), .NUM_INIT(NUM_INIT), .DW(DW), .INIT_SEC_RST(INIT_SEC_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_sec(cfg_sec),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_err(cfg_rsp_err),
    .cfg_rsp_rdata(cfg_rsp_rdata),
    .zone_ns(zone_ns_q), .ovr_en(ovr_en_q), .ovr_val(ovr_val_q)
  );

  fw_decide #(
    .NUM_TGT(NUM_TGT), .NUM_INIT(NUM_INIT), .IDXW(IDXW), .IW(IW)
  ) u_decide (
    .idx(req_idx), .init(up_req_init), .req_sec(up_req_sec),
    .zone_ns(zone_ns_q), .ovr_en(ovr_en_q), .ovr_val(ovr_val_q),
    .allow(allow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_req_valid <= 1'b0;
      tgt_req_idx   <= '0;
      tgt_req_write <= 1'b0;
      tgt_req_addr  <= '0;
      tgt_req_wdata <= '0;
      up_rsp_valid  <= 1'b0;
      up_rsp_err    <= 1'b0;
      up_rsp_rdata  <= '0;
    end else begin
      tgt_req_valid <= up_req_valid && allow;
      if (up_req_valid && allow) begin
        tgt_req_idx   <= req_idx;
        tgt_req_write <= up_req_write;
        tgt_req_addr  <= up_req_addr;
        tgt_req_wdata <= up_req_wdata;
      end
      if (up_req_valid && !allow) begin
        up_rsp_valid <= 1'b1;
        up_rsp_err   <= 1'b1;
        up_rsp_rdata <= '0;
      end else begin
        up_rsp_valid <= tgt_rsp_valid;
        up_rsp_err   <= tgt_rsp_valid && tgt_rsp_err;
        up_rsp_rdata <= tgt_rsp_valid ? tgt_rsp_rdata : '0;
      end
    end
  end
endmodule

// File: rtl/fw_target_gate_chk.sv
module fw_target_gate_chk #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int NUM_TGT  = 6,
  parameter int NUM_INIT = 4,
  parameter int IDXW     = 3,
  parameter int IW       = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                up_req_valid,
  input logic [AW-1:0]       up_req_addr,
  input logic [IW-1:0]       up_req_init,
  input logic                up_req_sec,
  input logic                up_rsp_valid,
  input logic                up_rsp_err,
  input logic [DW-1:0]       up_rsp_rdata,
  input logic                tgt_req_valid,
  input logic [IDXW-1:0]     tgt_req_idx,
  input logic                tgt_rsp_valid,
  input logic                cfg_valid,
  input logic                cfg_sec,
  input logic                cfg_rsp_valid,
  input logic                cfg_rsp_err,
  input logic [DW-1:0]       cfg_rsp_rdata,
  input logic [NUM_TGT-1:0]  zone_ns_q,
  input logic [NUM_INIT-1:0] ovr_en_q,
  input logic [NUM_INIT-1:0] ovr_val_q
);
  logic [IDXW-1:0] c_idx;
  logic            c_idx_ok;
  logic            c_sec;

  assign c_idx    = up_req_addr[AW-1 -: IDXW];
  assign c_idx_ok = {1'b0, c_idx} < (IDXW+1)'(NUM_TGT);
  assign c_sec    = ovr_en_q[up_req_init] ? ovr_val_q[up_req_init] : up_req_sec;

  // R2
  sec_tgt_block_chk: assert property (@(posedge clk) disable iff (rst)
    (up_req_valid && c_idx_ok && !zone_ns_q[c_idx] && !c_sec)
    |=> (!tgt_req_valid && up_rsp_valid && up_rsp_err && up_rsp_rdata == '0));

  // R3
  pass_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (up_req_valid && c_idx_ok && (zone_ns_q[c_idx] || c_sec))
    |=> (tgt_req_valid && tgt_req_idx == $past(c_idx)));

  // R6
  bad_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (up_req_valid && !c_idx_ok) |=> (!tgt_req_valid && up_rsp_valid && up_rsp_err));

  // R8
  cfg_ns_err_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_sec) |=> (cfg_rsp_valid && cfg_rsp_err && cfg_rsp_rdata == '0));

  // R8
  cfg_ns_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !cfg_sec) |=> ($stable(zone_ns_q) && $stable(ovr_en_q) && $stable(ovr_val_q)));

  // R7
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!up_req_valid && !tgt_rsp_valid) |=> !up_rsp_valid);
endmodule

bind fw_target_gate fw_target_gate_chk #(
  .AW(AW), .DW(DW), .NUM_TGT(NUM_TGT), .NUM_INIT(NUM_INIT), .IDXW(IDXW), .IW(IW)
) u_chk (
  .clk(clk), .rst(rst),
  .up_req_valid(up_req_valid), .up_req_addr(up_req_addr),
  .up_req_init(up_req_init), .up_req_sec(up_req_sec),
  .up_rsp_valid(up_rsp_valid), .up_rsp_err(up_rsp_err), .up_rsp_rdata(up_rsp_rdata),
  .tgt_req_valid(tgt_req_valid), .tgt_req_idx(tgt_req_idx),
  .tgt_rsp_valid(tgt_rsp_valid),
  .cfg_valid(cfg_valid), .cfg_sec(cfg_sec),
  .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_err(cfg_rsp_err), .cfg_rsp_rdata(cfg_rsp_rdata),
  .zone_ns_q(zone_ns_q), .ovr_en_q(ovr_en_q), .ovr_val_q(ovr_val_q)
);

// File: tb/fw_target_gate_tb.sv
module fw_target_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IDXW = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_req_valid = 0, up_req_write = 0, up_req_sec = 0;
  logic [AW-1:0] up_req_addr = '0;
  logic [DW-1:0] up_req_wdata = '0;
  logic [IW-1:0] up_req_init = '0;
  logic up_rsp_valid, up_rsp_err;
  logic [DW-1:0] up_rsp_rdata;
  logic tgt_req_valid, tgt_req_write;
  logic [IDXW-1:0] tgt_req_idx;
  logic [AW-1:0] tgt_req_addr;
  logic [DW-1:0] tgt_req_wdata;
  logic tgt_rsp_valid = 0, tgt_rsp_err = 0;
  logic [DW-1:0] tgt_rsp_rdata = '0;
  logic cfg_valid = 0, cfg_write = 0, cfg_sec = 0;
  logic [1:0] cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic cfg_rsp_valid, cfg_rsp_err;
  logic [DW-1:0] cfg_rsp_rdata;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_target_gate u_dut (
    .clk(clk), .rst(rst),
    .up_req_valid(up_req_valid), .up_req_write(up_req_write), .up_req_addr(up_req_addr),
    .up_req_wdata(up_req_wdata), .up_req_init(up_req_init), .up_req_sec(up_req_sec),
    .up_rsp_valid(up_rsp_valid), .up_rsp_err(up_rsp_err), .up_rsp_rdata(up_rsp_rdata),
    .tgt_req_valid(tgt_req_valid), .tgt_req_idx(tgt_req_idx), .tgt_req_write(tgt_req_write),
    .tgt_req_addr(tgt_req_addr), .tgt_req_wdata(tgt_req_wdata),
    .tgt_rsp_valid(tgt_rsp_valid), .tgt_rsp_err(tgt_rsp_err), .tgt_rsp_rdata(tgt_rsp_rdata),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_sec(cfg_sec), .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_err(cfg_rsp_err),
    .cfg_rsp_rdata(cfg_rsp_rdata)
  );

  // {init[7:6], sec[5], idx[4:2], write[1], expect_pass[0]}
  localparam logic [7:0] VEC [7] = '{
    8'b00_0_000_1_1,  // forced-secure initiator 0 reaches secure target 0
    8'b10_0_000_0_0,  // non-secure initiator 2 blocked at secure target
    8'b10_1_001_0_1,  // secure flag passes
    8'b11_0_101_1_0,  // non-secure write blocked at last target
    8'b10_1_110_0_0,  // index 6 has no target
    8'b01_0_111_0_0,  // index 7 has no target even when secure
    8'b11_1_101_1_1   // secure write to last target passes
  };

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(input logic [IW-1:0] init, input logic sec, input logic [IDXW-1:0] idx,
                     input logic wr, input bit exp_pass, input string req);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    a = {idx, 13'h0123 + 13'(init)};
    d = {16'h5A5A, 3'b0, init, sec, idx, wr, 5'h0};
    @(negedge clk);
    up_req_valid = 1; up_req_init = init; up_req_sec = sec;
    up_req_write = wr; up_req_addr = a; up_req_wdata = d;
    @(negedge clk);
    up_req_valid = 0;
    chk(tgt_req_valid == exp_pass, {req, " forward"}, DW'(tgt_req_valid), DW'(exp_pass));
    chk(up_rsp_valid == !exp_pass && up_rsp_err == !exp_pass && (exp_pass || up_rsp_rdata == '0),
        {req, " error response"}, {up_rsp_valid, up_rsp_err, up_rsp_rdata[29:0]},
        {!exp_pass, !exp_pass, 30'h0});
    if (exp_pass && tgt_req_valid) begin
      chk(tgt_req_idx == idx && tgt_req_addr == a && tgt_req_wdata == d && tgt_req_write == wr,
          "R3 forwarded fields", {tgt_req_write, tgt_req_idx, 12'h0, tgt_req_addr},
          {wr, idx, 12'h0, a});
      tgt_rsp_valid = 1; tgt_rsp_rdata = 32'hA500_0000 | DW'(idx);
      tgt_rsp_err = (idx == 3'd1);
      @(negedge clk);
      tgt_rsp_valid = 0;
      chk(up_rsp_valid && up_rsp_rdata == (32'hA500_0000 | DW'(idx)) &&
          up_rsp_err == (idx == 3'd1) && !tgt_req_valid,
          "R7 relayed response", up_rsp_rdata, 32'hA500_0000 | DW'(idx));
    end
  endtask

  task automatic cfg_acc(input logic sec, input logic wr, input logic [1:0] sel,
                         input logic [DW-1:0] wd, input bit exp_err,
                         input logic [DW-1:0] exp_rd, input string req);
    @(negedge clk);
    cfg_valid = 1; cfg_sec = sec; cfg_write = wr; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    cfg_valid = 0;
    chk(cfg_rsp_valid && cfg_rsp_err == exp_err, {req, " status"},
        {cfg_rsp_valid, cfg_rsp_err}, {1'b1, exp_err});
    chk(cfg_rsp_rdata == exp_rd, {req, " data"}, cfg_rsp_rdata, exp_rd);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(!up_rsp_valid && !tgt_req_valid && !cfg_rsp_valid, "R1 reset outputs idle",
        {up_rsp_valid, tgt_req_valid, cfg_rsp_valid}, 0);
    cfg_acc(1, 0, 2'd0, 0, 0, 32'h0, "R1 zone bits reset secure");
    cfg_acc(1, 0, 2'd1, 0, 0, 32'h3, "R5 override enable reset");
    cfg_acc(1, 0, 2'd2, 0, 0, 32'h3, "R5 override value reset");

    for (int i = 0; i < 7; i++) begin
      txn(VEC[i][7:6], VEC[i][5], VEC[i][4:2], VEC[i][1], VEC[i][0],
          $sformatf("R2/R4/R6 vector %0d", i));
    end

    cfg_acc(0, 0, 2'd0, 0, 1, 32'h0, "R8 non-secure read rejected");
    cfg_acc(0, 1, 2'd0, 32'h3F, 1, 32'h0, "R8 non-secure write rejected");
    cfg_acc(1, 0, 2'd0, 0, 0, 32'h0, "R8 zone unchanged after rejected write");
    cfg_acc(1, 1, 2'd3, 32'h1, 1, 32'h0, "R9 unused select write");
    cfg_acc(1, 0, 2'd3, 0, 1, 32'h0, "R9 unused select read");
    cfg_acc(1, 1, 2'd0, 32'hFFFF_FF04, 0, 32'h0, "R9 secure zone write");
    cfg_acc(1, 0, 2'd0, 0, 0, 32'h04, "R9 zone read back");

    txn(2'd3, 0, 3'd2, 0, 1, "R3 non-secure reaches non-secure target");
    txn(2'd3, 1, 3'd2, 1, 1, "R3 secure reaches non-secure target");
    txn(2'd3, 0, 3'd3, 0, 0, "R2 secure target still blocked");

    cfg_acc(1, 1, 2'd1, 32'hB, 0, 32'h0, "R9 override enable write");
    cfg_acc(1, 1, 2'd2, 32'h3, 0, 32'h0, "R9 override value write");
    txn(2'd3, 1, 3'd3, 0, 0, "R4 forced non-secure ignores request flag");
    txn(2'd3, 1, 3'd2, 0, 1, "R4 forced non-secure reaches non-secure target");
    txn(2'd2, 1, 3'd0, 0, 1, "R4 unforced initiator uses request flag");

    // R10: zone write and request in the same cycle
    @(negedge clk);
    cfg_valid = 1; cfg_sec = 1; cfg_write = 1; cfg_sel = 2'd0; cfg_wdata = 32'h14;
    up_req_valid = 1; up_req_init = 2'd2; up_req_sec = 0; up_req_write = 0;
    up_req_addr = {3'd4, 13'h0}; up_req_wdata = '0;
    @(negedge clk);
    cfg_valid = 0; up_req_valid = 0;
    chk(up_rsp_valid && up_rsp_err && !tgt_req_valid, "R10 old zone value used",
        {up_rsp_valid, up_rsp_err, tgt_req_valid}, 3'b110);
    chk(cfg_rsp_valid && !cfg_rsp_err, "R10 zone write accepted",
        {cfg_rsp_valid, cfg_rsp_err}, 2'b10);
    txn(2'd2, 0, 3'd4, 0, 1, "R10 new zone value applies to next request");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule